// File: doc/BRIEF.md
# Two-Letter Pattern Recognizer (Parallel NFA)

This block watches a stream of letters drawn from the alphabet {a, b} and raises a flag whenever the letters consumed since the last restart form a word of the language (ab+b)*ba. It does this without determinizing the expression. Each state of the four-state nondeterministic automaton gets its own flip-flop. On every accepted letter, all currently active states move forward together. In effect, the subset construction is carried out in hardware as the letters arrive.

A producer presents one letter per cycle with a valid strobe. A synchronous restart begins a new word at any time. The accept flag reads straight from the state register, so it reflects every letter up to and including the one taken at the previous clock edge.

Top module: `regex_nfa_rec`

## Requirements
- R1: After the asynchronous reset is released, only the start state s0 is active and `accept_o` is low.
- R2: Letter code 0 means a and 1 means b. On a taken letter, the active set advances along s0-a->s1, s1-b->s0, s0-b->s0, s0-b->s2 and s2-a->s3, all in one clock tick. On b, s0 activates both s0 and s2.
- R3: `accept_o` is high exactly when s3 is in the active set. It changes in the cycle after the edge that takes the letter.
- R4: Once a letter has been taken, `accept_o` is high if and only if the letters taken since the last restart or reset spell a word in (ab+b)*ba.
- R5: While `sym_valid_i` is low and `restart_i` is low, the active set and `accept_o` hold their values.
- R6: If the active set becomes empty, for example after a from s1 or s3, it stays empty and `accept_o` stays low until restart.
- R7: `restart_i` is synchronous and takes priority over a letter in the same cycle. It reloads the set containing only s0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| restart_i | input | 1 | Synchronous restart to the start state |
| sym_valid_i | input | 1 | A letter is present this cycle |
| sym_i | input | 1 | Letter code: 0 = a, 1 = b |
| accept_o | output | 1 | Letters since restart form a word of the language |

## Verification
Short directed words separate the accepting paths from the ones that end one letter short. The word "ba" takes the shortest path to accept. The words "abba" and "bbba" exercise the s1 loop and the two-way split on b. A trailing b after an accept shows that acceptance is not sticky. A double a drives the active set empty, and the bench checks that no later b/a combination revives it. Idle gaps test hold, and a restart raised together with a letter tests priority. A long pseudo-random letter stream with occasional restarts and idle cycles is then checked against a deterministic automaton kept in the bench. Any difference in the subset tracking shows up as a mismatch on the flag.

// File: rtl/regex_nfa_pkg.sv
package regex_nfa_pkg;
    localparam int N_ST   = 4;
    localparam int IDX_W  = $clog2(N_ST);
    localparam int N_EDGE = 5;

    localparam logic SYM_A = 1'b0;
    localparam logic SYM_B = 1'b1;

    localparam int ST_START = 0;
    localparam int ST_FINAL = 3;

    typedef logic [N_ST-1:0] st_vec_t;

    typedef struct packed {
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] dst;
        logic             sym;
    } edge_t;

    typedef struct packed {
        st_vec_t act;
    } regs_t;

    localparam st_vec_t START_SET = st_vec_t'(1) << ST_START;

    // transition list of the automaton for (ab+b)*ba
    localparam edge_t EDGES [N_EDGE] = '{
        '{src: 2'd0, dst: 2'd1, sym: SYM_A},
        '{src: 2'd1, dst: 2'd0, sym: SYM_B},
        '{src: 2'd0, dst: 2'd0, sym: SYM_B},
        '{src: 2'd0, dst: 2'd2, sym: SYM_B},
        '{src: 2'd2, dst: 2'd3, sym: SYM_A}
    };
endpackage

// File: rtl/regex_nfa_step.sv
module regex_nfa_step
    import regex_nfa_pkg::*;
(
    input  st_vec_t cur_i,
    input  logic    sym_i,
    output st_vec_t nxt_o
);
    // every active source fires all of its matching edges at once
    always_comb begin
        nxt_o = '0;
        for (int e = 0; e < N_EDGE; e++) begin
            if (cur_i[EDGES[e].src] && (sym_i == EDGES[e].sym)) begin
                nxt_o[EDGES[e].dst] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/regex_nfa_rec.sv
module regex_nfa_rec
    import regex_nfa_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    input  logic sym_valid_i,
    input  logic sym_i,
    output logic accept_o
);
    regs_t   regs_d, regs_q;
    st_vec_t step_nxt;

    regex_nfa_step step_i (
        .cur_i (regs_q.act),
        .sym_i (sym_i),
        .nxt_o (step_nxt)
    );

    always_comb begin
        regs_d = regs_q;
        if (restart_i) begin
            regs_d.act = START_SET;
        end else if (sym_valid_i) begin
            regs_d.act = step_nxt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            regs_q.act <= START_SET;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign accept_o = regs_q.act[ST_FINAL];

    // R7
    restart_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_i |=> (regs_q.act == START_SET));

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && !sym_valid_i) |=> $stable(regs_q.act));

    // R6
    empty_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (regs_q.act == '0 && !restart_i) |=> (regs_q.act == '0));

    // R3
    accept_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(accept_o) |-> $past(sym_valid_i && !restart_i && sym_i == SYM_A && regs_q.act[2]));

    // R2
    split_on_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!restart_i && sym_valid_i && sym_i == SYM_B && regs_q.act[0])
            |=> (regs_q.act[0] && regs_q.act[2]));
endmodule

// File: tb/regex_nfa_rec_tb_top.sv
module regex_nfa_rec_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic restart = 1'b0;
    logic valid = 1'b0;
    logic sym = 1'b0;
    logic accept;

    int checks = 0;
    int errors = 0;
    int model = 0; // DFA: 0..3 = e0..e3, 4 = dead
    logic finished = 1'b0;

    always #4 clk = ~clk;

    regex_nfa_rec dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .restart_i   (restart),
        .sym_valid_i (valid),
        .sym_i       (sym),
        .accept_o    (accept)
    );

    function automatic int dfa_next(int s, logic b);
        case (s)
            0: return b ? 2 : 1;
            1: return b ? 0 : 4;
            2: return b ? 2 : 3;
            3: return b ? 0 : 4;
            default: return 4;
        endcase
    endfunction

    task automatic check(string tag);
        logic exp = (model == 3);
        checks++;
        if (accept !== exp) begin
            errors++;
            $display("FAIL %s: accept=%b expected=%b", tag, accept, exp);
        end
    endtask

    task automatic step(input logic v, input logic s, input logic r, input string tag);
        valid = v; sym = s; restart = r;
        @(posedge clk);
        #1;
        if (r) model = 0;
        else if (v) model = dfa_next(model, s);
        @(negedge clk);
        check(tag);
    endtask

    task automatic word(input string w, input string tag);
        for (int i = 0; i < w.len(); i++) begin
            step(1'b1, (w[i] == "b"), 1'b0, tag);
        end
    endtask

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: accept=%b expected=done", accept);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr = 32'h1d2c3b4a;
        repeat (3) @(negedge clk);
        check("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check("R1");
        word("ba", "R3 R4");
        step(1'b0, 1'b1, 1'b0, "R5");
        step(1'b0, 1'b0, 1'b0, "R5");
        step(1'b0, 1'b1, 1'b0, "R5");
        word("b", "R4");
        word("abba", "R2");
        word("bbba", "R2");
        word("b", "R2");
        word("aa", "R6");
        word("bababba", "R6");
        step(1'b1, 1'b0, 1'b1, "R7");
        word("ba", "R7");
        step(1'b0, 1'b0, 1'b1, "R7");
        word("abbba", "R4");
        for (int n = 0; n < 2000; n++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step((lfsr[3:2] != 2'b00), lfsr[0], (lfsr[9:5] == 5'd0), "R4");
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule